// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the software-facing part of one serial port. A processor reaches it through a 32-bit register bus with per-byte write enables, a 256-byte window addressed by word, and big-endian byte lanes. The block holds six control and status words and two byte queues. The transmit queue is written by software and drained onto a byte stream toward an external link model. The receive queue is filled from a byte stream and read by software. Bit serialization, baud timing, handshaking lines and error detection sit outside the block, and the frame is always eight data bits, no parity and one stop bit.

A single level interrupt tells software that receive data is waiting or that the transmit queue has emptied. Each cause is latched in a status word, gated by an enable word, and cleared by writing zero to it. A FIFO-control word can flush either queue, but only when its enable bit is set in the same written value. Setting the unsupported DMA enable raises an error output.

Top module: `serial_ctl`

## Requirements
- R1: During reset and right after it, word 0 (line control) reads 0x40000000, word 5 (baud control) reads 0x03FF0000, words 1 to 4 read 0, irq is 0, tx_valid is 0 and rx_ready is 1. Word index is the byte offset divided by four.
- R2: A write stores only the writable bits: line control (word 0) mask 0xE17F0000, interrupt enable (word 2) mask 0x000F0000, FIFO control (word 4) mask 0x001F0000, baud control (word 5) mask 0x03FF0000. Line status (word 1) ignores writes and reads 0. Words with no register read 0.
- R3: Byte lanes are big-endian: bus_be[3] selects bits 31:24 (byte offset 0), bus_be[2] bits 23:16, bus_be[1] bits 15:8, bus_be[0] bits 7:0. A write changes only enabled lanes.
- R4: A read of word 12 (receive data) with bus_be[3] set pops the oldest received byte and returns it in bits 31:24, other bits 0. An empty queue returns 0. A read without bus_be[3] returns 0 and pops nothing.
- R5: A write to word 8 (transmit data) with bus_be[3] set queues bits 31:24; without bus_be[3] nothing is queued. A write while 8 bytes are held is dropped. Reads of word 8 return 0.
- R6: tx_valid is high whenever the transmit queue is non-empty, tx_data shows the oldest byte, and one byte leaves per cycle while tx_ready is high, in write order.
- R7: The receive queue holds 8 bytes; rx_ready is low while it is full, and a byte is taken on each clock edge where rx_valid and rx_ready are both high.
- R8: In the interrupt status word (word 3, mask 0x00070000), bit 16 is set on each edge at which the receive queue is non-empty and bit 17 on each edge at which the transmit queue is empty; both then stay set until cleared, so a bit shows one cycle after its condition first holds.
- R9: A write to the status word ANDs each enabled written byte into the stored byte, clearing bits written as 0; if a set condition still holds on that edge the bit stays set.
- R10: irq is high exactly when some bit is 1 in both status and enable, changing in the same cycle as either word.
- R11: dma_err follows interrupt enable bit 19.
- R12: FIFO control bit 16 enables flushing, bit 17 flushes the receive queue and bit 18 the transmit queue; a queue is flushed on a write only when bit 16 and its own bit are both 1 in the value after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_word | input | 6 | Word index within the 256-byte window |
| bus_be | input | 4 | Byte-lane enables, bit 3 is byte offset 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| irq | output | 1 | Level interrupt |
| dma_err | output | 1 | Unsupported DMA requested |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Link accepts a transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Receive byte |

## Verification
The hardest state to reach is a cleared transmit-empty status bit, because the bit is re-set on every edge at which the transmit queue is empty. The bench holds tx_ready low, queues bytes, clears the status and enables that cause, then lets the queue drain and checks that irq stays low on the cycle the queue empties and rises one cycle later. The receive side is pushed past full to show rx_ready dropping at eight bytes, and every register is swept over all sixteen byte-enable patterns with several data words.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [5:0] W_LINE   = 6'd0;
  localparam logic [5:0] W_LSTAT  = 6'd1;
  localparam logic [5:0] W_IEN    = 6'd2;
  localparam logic [5:0] W_ISTAT  = 6'd3;
  localparam logic [5:0] W_FCTL   = 6'd4;
  localparam logic [5:0] W_BAUD   = 6'd5;
  localparam logic [5:0] W_TXDATA = 6'd8;
  localparam logic [5:0] W_RXDATA = 6'd12;

  localparam logic [BUS_W-1:0] LINE_MASK  = 32'hE17F_0000;
  localparam logic [BUS_W-1:0] IEN_MASK   = 32'h000F_0000;
  localparam logic [BUS_W-1:0] ISTAT_MASK = 32'h0007_0000;
  localparam logic [BUS_W-1:0] FCTL_MASK  = 32'h001F_0000;
  localparam logic [BUS_W-1:0] BAUD_MASK  = 32'h03FF_0000;

  localparam logic [BUS_W-1:0] LINE_RST = 32'h4000_0000;
  localparam logic [BUS_W-1:0] BAUD_RST = 32'h03FF_0000;

  localparam int ST_RX   = 16;
  localparam int ST_TX   = 17;
  localparam int EN_DMA  = 19;
  localparam int FC_EN   = 16;
  localparam int FC_RXRS = 17;
  localparam int FC_TXRS = 18;

  // expand byte enables into a bit mask
  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // replace enabled lanes, keep only writable bits
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
      input logic [BUS_W-1:0] wd, input logic [LANES-1:0] be, input logic [BUS_W-1:0] mask);
    logic [BUS_W-1:0] m;
    m = lane_bits(be);
    return mask & ((old_v & ~m) | (wd & m));
  endfunction

  // AND enabled lanes into the stored value
  function automatic logic [BUS_W-1:0] lane_and(input logic [BUS_W-1:0] old_v,
      input logic [BUS_W-1:0] wd, input logic [LANES-1:0] be, input logic [BUS_W-1:0] mask);
    logic [BUS_W-1:0] m;
    m = lane_bits(be);
    return mask & old_v & (wd | ~m);
  endfunction
endpackage

// File: rtl/serial_byte_fifo.sv
module serial_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [5:0]       word,
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  input  logic             rx_has_data,
  input  logic             tx_is_empty,
  output logic [BUS_W-1:0] line_q,
  output logic [BUS_W-1:0] ien_q,
  output logic [BUS_W-1:0] ist_q,
  output logic [BUS_W-1:0] fctl_q,
  output logic [BUS_W-1:0] baud_q,
  output logic             rx_flush,
  output logic             tx_flush
);
  logic             wr_fctl, wr_ist;
  logic [BUS_W-1:0] fctl_next, ist_next, ist_set;

  assign wr_fctl   = wr_en && (word == W_FCTL);
  assign wr_ist    = wr_en && (word == W_ISTAT);
  assign fctl_next = lane_merge(fctl_q, wdata, be, FCTL_MASK);
  assign rx_flush  = wr_fctl && fctl_next[FC_EN] && fctl_next[FC_RXRS];
  assign tx_flush  = wr_fctl && fctl_next[FC_EN] && fctl_next[FC_TXRS];

  always_comb begin
    ist_set = '0;
    ist_set[ST_RX] = rx_has_data;
    ist_set[ST_TX] = tx_is_empty;
    ist_next = (wr_ist ? lane_and(ist_q, wdata, be, ISTAT_MASK) : ist_q) | ist_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= LINE_RST;
      ien_q  <= '0;
      ist_q  <= '0;
      fctl_q <= '0;
      baud_q <= BAUD_RST;
    end else begin
      ist_q <= ist_next;
      if (wr_fctl) fctl_q <= fctl_next;
      if (wr_en && word == W_LINE) line_q <= lane_merge(line_q, wdata, be, LINE_MASK);
      if (wr_en && word == W_IEN)  ien_q  <= lane_merge(ien_q, wdata, be, IEN_MASK);
      if (wr_en && word == W_BAUD) baud_q <= lane_merge(baud_q, wdata, be, BAUD_MASK);
    end
  end
endmodule

// File: rtl/serial_ctl.sv
module serial_ctl
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [5:0]        bus_word,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              dma_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data
);
  logic             wr_ev, rd_ev;
  logic             tx_push_ev, tx_pop_ev, rx_push_ev, rx_pop_ev;
  logic             rx_flush_ev, tx_flush_ev;
  logic [CW-1:0]    rx_count, tx_count;
  logic [DATA_W-1:0] rx_head;
  logic [BUS_W-1:0] line_q, ien_q, ist_q, fctl_q, baud_q;

  assign wr_ev      = bus_sel && bus_wr;
  assign rd_ev      = bus_sel && !bus_wr;
  assign tx_push_ev = wr_ev && (bus_word == W_TXDATA) && bus_be[LANES-1];
  assign rx_pop_ev  = rd_ev && (bus_word == W_RXDATA) && bus_be[LANES-1] && (rx_count != '0);
  assign tx_valid   = (tx_count != '0);
  assign tx_pop_ev  = tx_valid && tx_ready;
  assign rx_ready   = (rx_count != CW'(FIFO_DEPTH));
  assign rx_push_ev = rx_valid && rx_ready;

  serial_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ev), .word(bus_word), .be(bus_be),
    .wdata(bus_wdata), .rx_has_data(rx_count != '0), .tx_is_empty(tx_count == '0),
    .line_q(line_q), .ien_q(ien_q), .ist_q(ist_q), .fctl_q(fctl_q), .baud_q(baud_q),
    .rx_flush(rx_flush_ev), .tx_flush(tx_flush_ev)
  );

  serial_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush_ev), .push(tx_push_ev),
    .din(bus_wdata[BUS_W-1 -: DATA_W]), .pop(tx_pop_ev), .dout(tx_data), .count(tx_count)
  );

  serial_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush_ev), .push(rx_push_ev),
    .din(rx_data), .pop(rx_pop_ev), .dout(rx_head), .count(rx_count)
  );

  assign irq     = |(ist_q & ien_q);
  assign dma_err = ien_q[EN_DMA];

  always_comb begin
    unique case (bus_word)
      W_LINE:   bus_rdata = line_q;
      W_IEN:    bus_rdata = ien_q;
      W_ISTAT:  bus_rdata = ist_q;
      W_FCTL:   bus_rdata = fctl_q;
      W_BAUD:   bus_rdata = baud_q;
      W_RXDATA: bus_rdata = rx_pop_ev ? {rx_head, {(BUS_W-DATA_W){1'b0}}} : '0;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_ctl_chk.sv
module serial_ctl_chk #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     rx_count,
  input logic [CW-1:0]     tx_count,
  input logic [31:0]       ist_q,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_pop_ev,
  input logic              rx_push_ev,
  input logic              rx_flush_ev,
  input logic              tx_flush_ev
);
  // R7
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(FIFO_DEPTH));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_flush_ev) |=> (tx_valid && $stable(tx_data)));

  // R8
  rx_status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |=> ist_q[16]);

  // R8
  tx_status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |=> ist_q[17]);

  // R4
  rx_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_ev && !rx_push_ev && !rx_flush_ev) |=> (rx_count + CW'(1) == $past(rx_count)));

  // R12
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_ev |=> (rx_count == '0));

  // R12
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_ev |=> (tx_count == '0));
endmodule

bind serial_ctl serial_ctl_chk #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count), .ist_q(ist_q),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_pop_ev(rx_pop_ev),
  .rx_push_ev(rx_push_ev), .rx_flush_ev(rx_flush_ev), .tx_flush_ev(tx_flush_ev)
);

// File: tb/sim_serial_ctl.sv
`timescale 1ns/1ps
module sim_serial_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_word = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, dma_err, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  int          vec = 0, bad = 0;

  always #4 clk = ~clk;

  serial_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dma_err(dma_err), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] w, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w; bus_be = be;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // model of a lane write: enabled bytes replaced, then writable mask
  function automatic logic [31:0] exp_merge(input logic [31:0] o, input logic [31:0] d,
                                            input logic [3:0] be, input logic [31:0] m);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r & m;
  endfunction

  function automatic logic [31:0] exp_and(input logic [31:0] o, input logic [31:0] d,
                                          input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = r[8*i +: 8] & d[8*i +: 8];
    return r & 32'h0007_0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] m_line, m_ien, m_ist, m_fctl, m_baud;
    logic [31:0] pats [4];
    logic [5:0]  words [6];
    logic [31:0] masks [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5C3_5A3C; pats[3] = 32'h1234_5678;

    // R1 reset state, read while reset is held
    repeat (2) @(negedge clk);
    bus_read(6'd0, 4'hF, rd); chk("R1 line", rd, 32'h4000_0000);
    bus_read(6'd5, 4'hF, rd); chk("R1 baud", rd, 32'h03FF_0000);
    for (int w = 1; w <= 4; w++) begin
      bus_read(6'(w), 4'hF, rd); chk("R1 zero word", rd, 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R9 R10 R11 register sweep over all byte-enable patterns
    m_line = 32'h4000_0000; m_ien = 0; m_ist = 32'h0002_0000; m_fctl = 0; m_baud = 32'h03FF_0000;
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < 4; p++) begin
        for (int b = 0; b < 16; b++) begin
          bus_write(6'(r), 4'(b), pats[p]);
          case (r)
            0: begin m_line = exp_merge(m_line, pats[p], 4'(b), 32'hE17F_0000);
                     bus_read(6'd0, 4'hF, rd); chk("R2 R3 line", rd, m_line); end
            1: begin bus_read(6'd1, 4'hF, rd); chk("R2 line status", rd, 32'h0); end
            2: begin m_ien = exp_merge(m_ien, pats[p], 4'(b), 32'h000F_0000);
                     bus_read(6'd2, 4'hF, rd); chk("R2 R3 enable", rd, m_ien);
                     chk("R11 dma_err", {31'd0, dma_err}, {31'd0, m_ien[19]}); end
            3: begin m_ist = exp_and(m_ist, pats[p], 4'(b)) | 32'h0002_0000;
                     bus_read(6'd3, 4'hF, rd); chk("R9 status", rd, m_ist); end
            4: begin m_fctl = exp_merge(m_fctl, pats[p], 4'(b), 32'h001F_0000);
                     bus_read(6'd4, 4'hF, rd); chk("R2 R3 fifo ctrl", rd, m_fctl); end
            default: begin m_baud = exp_merge(m_baud, pats[p], 4'(b), 32'h03FF_0000);
                     bus_read(6'd5, 4'hF, rd); chk("R2 R3 baud", rd, m_baud); end
          endcase
          chk("R10 irq", {31'd0, irq}, {31'd0, |(m_ist & m_ien)});
        end
      end
    end
    foreach (words[i]) words[i] = 6'(i);
    masks[0] = 0;
    bus_write(6'd2, 4'hF, 32'h0); bus_write(6'd4, 4'hF, 32'h0);
    // R2 unmapped words
    bus_read(6'd6, 4'hF, rd);  chk("R2 unmapped 6", rd, 32'h0);
    bus_read(6'd9, 4'hF, rd);  chk("R2 unmapped 9", rd, 32'h0);
    bus_read(6'd63, 4'hF, rd); chk("R2 unmapped 63", rd, 32'h0);

    // R5 lower lanes do not queue
    bus_write(6'd8, 4'b0111, 32'hFFFF_FFFF);
    chk("R5 no push low lanes", {31'd0, tx_valid}, 32'd0);
    for (int i = 0; i < 10; i++) bus_write(6'd8, 4'b1000, {8'(8'h50 + i), 24'h0});
    bus_read(6'd8, 4'hF, rd); chk("R5 tx read zero", rd, 32'h0);
    bus_write(6'd3, 4'b0100, 32'h0);
    bus_read(6'd3, 4'hF, rd); chk("R9 tx status cleared", rd, 32'h0);
    bus_write(6'd2, 4'hF, 32'h0002_0000);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    // R6 drain, 8 bytes kept (R5 drop of two)
    @(negedge clk); tx_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
      chk("R6 tx_data", {24'd0, tx_data}, 32'(8'h50 + k));
      @(negedge clk);
    end
    chk("R5 R6 drained", {31'd0, tx_valid}, 32'd0);
    chk("R8 tx status lag", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 R10 irq rises", {31'd0, irq}, 32'd1);
    bus_read(6'd3, 4'hF, rd); chk("R8 tx status", rd, 32'h0002_0000);

    // R7 receive to full
    bus_write(6'd2, 4'hF, 32'h0001_0000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(8'h30 + i);
      #1 chk("R7 rx_ready", {31'd0, rx_ready}, {31'd0, i < 8});
    end
    @(negedge clk); rx_valid = 1'b0;
    chk("R10 rx irq", {31'd0, irq}, 32'd1);
    bus_read(6'd12, 4'b0111, rd); chk("R4 low lanes", rd, 32'h0);
    for (int k = 0; k < 8; k++) begin
      bus_read(6'd12, 4'b1000, rd); chk("R4 pop", rd, {8'(8'h30 + k), 24'h0});
    end
    bus_read(6'd12, 4'b1000, rd); chk("R4 empty", rd, 32'h0);
    bus_read(6'd3, 4'hF, rd); chk("R8 sticky rx", rd, 32'h0003_0000);
    bus_write(6'd3, 4'b0100, 32'h0);
    bus_read(6'd3, 4'hF, rd); chk("R9 clear rx", rd, 32'h0002_0000);
    chk("R10 irq clear", {31'd0, irq}, 32'd0);

    // R12 flush gating
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(8'h70 + i);
    end
    @(negedge clk); rx_valid = 1'b0;
    bus_write(6'd4, 4'hF, 32'h0002_0000);
    bus_read(6'd12, 4'b1000, rd); chk("R12 no flush w/o enable", rd, 32'h7000_0000);
    bus_write(6'd4, 4'hF, 32'h0003_0000);
    bus_read(6'd12, 4'b1000, rd); chk("R12 rx flushed", rd, 32'h0);
    tx_ready = 1'b0;
    bus_write(6'd8, 4'b1000, 32'h9900_0000);
    chk("R12 tx queued", {31'd0, tx_valid}, 32'd1);
    bus_write(6'd4, 4'hF, 32'h0005_0000);
    chk("R12 tx flushed", {31'd0, tx_valid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule